// File: doc/BRIEF.md
# Split Pending/Enable Interrupt Controller

This block merges five interrupt sources into a single interrupt line for a host processor. The sources are an external input, two timers, an asynchronous serial port and a synchronous serial port. Each source delivers a one-cycle event pulse. When the source is enabled, the pulse sets a pending latch. The host line stays high while any latch is set.

Software reaches the block through one 16-bit register, and that register means different things for reads and writes. On a write, the low half loads the enable mask, and each 1 in the high half clears the pending latch of the matching source. On a read, the register returns the pending latches, not the value last written. Each half has its own byte-lane strobe, so software can change the mask without clearing anything, or clear latches without touching the mask.

Top module: `ictl_split_irq`

## Requirements
- R1: After reset the enable mask and all pending latches are zero, so `irq_out` is low and `bus_rdata` reads 0. Events that arrive before any enable write are not latched.
- R2: Source index i maps to enable bit i (wdata[i]), clear bit 8+i (wdata[8+i]) and read bit i (rdata[i]). The indices are: 0 external, 1 timer 1, 2 timer 2, 3 asynchronous serial, 4 synchronous serial. An event on an enabled source sets its bit on the next clock edge.
- R3: An event on a source whose enable bit is 0 has no effect on the pending latches.
- R4: A write with both lanes strobed (`bus_be` = 2'b11) loads the mask from wdata[4:0] and clears the latches selected by wdata[12:8], both in the same cycle.
- R5: `bus_rdata` returns the pending latches, never the value that was written.
- R6: A write strobing only the low lane (`bus_be` = 2'b01) loads the mask. It clears nothing, even when wdata[15:8] holds ones.
- R7: A write strobing only the high lane (`bus_be` = 2'b10) clears the selected latches and leaves the mask unchanged.
- R8: `irq_out` is high whenever any pending latch is set. It stays high until every latch has been cleared.
- R9: If an enabled event and a clear of the same source happen in the same cycle, the latch stays set.
- R10: An event is qualified by the mask held before that clock edge. An event in the same cycle as the write that enables its source is not latched.
- R11: `bus_rdata` bits 15 down to 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | 5 | One-cycle event pulse for each source |
| bus_wr | input | 1 | Register write strobe |
| bus_be | input | 2 | Lane strobes: bit 0 selects the mask half, bit 1 selects the clear half |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Pending latches, zero-extended |
| irq_out | output | 1 | Host interrupt, high while any latch is set |

## Verification
The hardest situations to reach are a register write that lands in the same cycle as a source event. Two cases matter: the write clears the bit that the event is setting, and the write enables the source that is firing. The driver task applies the event vector and the register access in one call, so both land on the same edge. The scoreboard predicts the result from the mask held before that edge. Lane-only writes carry ones in the lane that is not strobed, so a lane leak shows up either in the readback or in the latching pattern of the next event.

// File: rtl/ictl_pkg.sv
`timescale 1ns/1ps
package ictl_pkg;
    parameter int unsigned NSRC   = 5;
    parameter int unsigned DATA_W = 16;

    typedef enum int unsigned {
        SRC_EXT   = 0,
        SRC_TMR1  = 1,
        SRC_TMR2  = 2,
        SRC_ASER  = 3,
        SRC_SSER  = 4
    } src_idx_e;

    // Lane strobe positions: low half carries the mask, high half the clears.
    localparam int unsigned LANE_MASK = 0;
    localparam int unsigned LANE_CLR  = 1;
endpackage

// File: rtl/ictl_regif.sv
`timescale 1ns/1ps
module ictl_regif #(
    parameter int unsigned NSRC   = ictl_pkg::NSRC,
    parameter int unsigned DATA_W = ictl_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        be,
    input  logic [DATA_W-1:0] wdata,
    output logic [NSRC-1:0]   en_q,
    output logic [NSRC-1:0]   clr_mask
);
    localparam int unsigned HALF = DATA_W / 2;
    localparam logic [DATA_W-1:0] USED =
        ({{(DATA_W-NSRC){1'b0}}, {NSRC{1'b1}}}) |
        ({{(DATA_W-NSRC){1'b0}}, {NSRC{1'b1}}} << HALF);

    typedef struct packed {
        logic [NSRC-1:0] en;
    } regif_state_t;

    regif_state_t st_d, st_q;
    logic         mask_wr;
    logic         clr_wr;
    logic         unused_wdata_bits;

    assign unused_wdata_bits = ^(wdata & ~USED);

    always_comb begin
        mask_wr  = wr & be[ictl_pkg::LANE_MASK];
        clr_wr   = wr & be[ictl_pkg::LANE_CLR];
        st_d     = st_q;
        clr_mask = '0;
        if (mask_wr) st_d.en = wdata[NSRC-1:0];
        if (clr_wr)  clr_mask = wdata[HALF +: NSRC];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q = st_q.en;
endmodule

// File: rtl/ictl_pend_cell.sv
`timescale 1ns/1ps
module ictl_pend_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic en,
    input  logic clr,
    output logic pend_q
);
    typedef struct packed {
        logic pend;
    } cell_state_t;

    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Clear first, then set: a qualified event overrides a same-cycle clear.
        if (clr)        st_d.pend = 1'b0;
        if (evt && en)  st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;
endmodule

// File: rtl/ictl_irq_merge.sv
`timescale 1ns/1ps
module ictl_irq_merge #(
    parameter int unsigned NSRC   = ictl_pkg::NSRC,
    parameter int unsigned DATA_W = ictl_pkg::DATA_W
) (
    input  logic [NSRC-1:0]   pend,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    always_comb begin
        rdata = {{(DATA_W-NSRC){1'b0}}, pend};
        irq   = |pend;
    end
endmodule

// File: rtl/ictl_split_irq.sv
`timescale 1ns/1ps
module ictl_split_irq #(
    parameter int unsigned NSRC   = ictl_pkg::NSRC,
    parameter int unsigned DATA_W = ictl_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_evt,
    input  logic              bus_wr,
    input  logic [1:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] clr_mask;
    logic [NSRC-1:0] pend_q;

    ictl_regif #(.NSRC(NSRC), .DATA_W(DATA_W)) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .be       (bus_be),
        .wdata    (bus_wdata),
        .en_q     (en_q),
        .clr_mask (clr_mask)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_cell
        ictl_pend_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (src_evt[g]),
            .en     (en_q[g]),
            .clr    (clr_mask[g]),
            .pend_q (pend_q[g])
        );
    end

    ictl_irq_merge #(.NSRC(NSRC), .DATA_W(DATA_W)) u_merge (
        .pend  (pend_q),
        .rdata (bus_rdata),
        .irq   (irq_out)
    );
endmodule

// File: rtl/ictl_split_irq_chk.sv
`timescale 1ns/1ps
module ictl_split_irq_chk #(
    parameter int unsigned NSRC   = ictl_pkg::NSRC,
    parameter int unsigned DATA_W = ictl_pkg::DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   src_evt,
    input logic              bus_wr,
    input logic [1:0]        bus_be,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_out,
    input logic [NSRC-1:0]   en_q
);
    localparam int unsigned HALF = DATA_W / 2;

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NSRC] == '0);  // R11

    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bus_rdata[NSRC-1:0] & $past(src_evt & en_q)) == $past(src_evt & en_q)));  // R9

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bus_rdata[NSRC-1:0] & ~$past(bus_rdata[NSRC-1:0]) & ~$past(src_evt & en_q)) == '0));  // R3

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be[1]) |=>
        ((bus_rdata[NSRC-1:0] & $past(bus_wdata[HALF +: NSRC]) & ~$past(src_evt & en_q)) == '0));  // R7

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be[0]) |=> (en_q == $past(bus_wdata[NSRC-1:0])));  // R6

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_be[0]) |=> $stable(en_q));  // R7

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (bus_rdata != '0));  // R8
endmodule

bind ictl_split_irq ictl_split_irq_chk #(.NSRC(NSRC), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_evt   (src_evt),
    .bus_wr    (bus_wr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .en_q      (en_q)
);

// File: tb/ictl_split_irq_bench.sv
`timescale 1ns/1ps
module ictl_split_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  src_evt;
    logic        bus_wr;
    logic [1:0]  bus_be;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        irq_out;

    always #10 clk = ~clk;

    ictl_split_irq u_ictl_split_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_evt   (src_evt),
        .bus_wr    (bus_wr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    typedef struct {
        logic [15:0] rd;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errors = 0;
    bit         done   = 0;
    logic [4:0] m_en   = '0;
    logic [4:0] m_pend = '0;

    // Driver: one cycle of stimulus, model update, expectation pushed.
    task automatic step(input logic [4:0] evt, input logic wr, input logic [1:0] be,
                        input logic [15:0] wd, input string tag);
        logic [4:0] clr;
        exp_t       e;
        src_evt = evt; bus_wr = wr; bus_be = be; bus_wdata = wd;
        clr    = (wr && be[1]) ? wd[12:8] : 5'b0;
        m_pend = (m_pend & ~clr) | (evt & m_en);
        if (wr && be[0]) m_en = wd[4:0];
        @(posedge clk); #2;
        src_evt = '0; bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
        e.rd  = {11'b0, m_pend};
        e.irq = |m_pend;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares outputs at the falling edge.
    always @(negedge clk) begin
        exp_t e;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (bus_rdata !== e.rd || irq_out !== e.irq) begin
                errors++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         e.tag, bus_rdata, irq_out, e.rd, e.irq);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; src_evt = '0; bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        step(5'h00, 0, 2'b00, 16'h0000, "R1 reset state");
        step(5'h1F, 0, 2'b00, 16'h0000, "R1 mask zero after reset");

        step(5'h00, 1, 2'b11, 16'h0001, "R4 word write enables external");
        step(5'h1F, 0, 2'b00, 16'h0000, "R3 disabled sources ignored");
        step(5'h00, 1, 2'b11, 16'h1F1F, "R4 word write clears and enables all");

        for (int i = 0; i < 5; i++) begin
            step(5'(1 << i), 0, 2'b00, 16'h0000, "R2 source bit mapping");
            step(5'h00, 1, 2'b10, 16'h1F00, "R7 upper lane clear");
        end

        step(5'h04, 0, 2'b00, 16'h0000, "R2 timer 2 latches");
        step(5'h00, 1, 2'b11, 16'h0013, "R5 read returns pending not written value");
        step(5'h1F, 0, 2'b00, 16'h0000, "R5 mask 13 applied");

        step(5'h00, 1, 2'b01, 16'hFF05, "R6 low lane write clears nothing");
        step(5'h00, 1, 2'b11, 16'h1F00, "R4 clear all, mask to zero");
        step(5'h1F, 0, 2'b00, 16'h0000, "R4 zero mask blocks events");

        step(5'h00, 1, 2'b01, 16'hFF05, "R6 low lane loads mask 05");
        step(5'h1F, 0, 2'b00, 16'h0000, "R6 mask 05 latches bits 0 and 2");
        step(5'h00, 1, 2'b10, 16'h011F, "R7 high lane clears bit 0 only");
        step(5'h1F, 0, 2'b00, 16'h0000, "R7 mask unchanged by high lane write");

        step(5'h00, 1, 2'b11, 16'h001F, "R8 enable all");
        step(5'h1F, 0, 2'b00, 16'h0000, "R11 all pending, upper bits zero");
        step(5'h00, 1, 2'b10, 16'h0100, "R8 irq held after partial clear");
        step(5'h00, 1, 2'b10, 16'h0600, "R8 irq held after partial clear");
        step(5'h00, 1, 2'b10, 16'h0800, "R8 irq held with one bit left");
        step(5'h00, 1, 2'b10, 16'h1000, "R8 irq drops after last clear");

        step(5'h02, 1, 2'b11, 16'h021F, "R9 event wins over same-cycle clear");
        step(5'h00, 1, 2'b11, 16'h1F07, "R10 clear all, mask 07");
        step(5'h08, 1, 2'b01, 16'h000F, "R10 event with same-cycle enable not latched");
        step(5'h08, 0, 2'b00, 16'h0000, "R10 event latched once enable held");

        while (sb.size() != 0) @(posedge clk);
        @(negedge clk); #1;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule